// File: doc/BRIEF.md
# Clock-Tree Reset Release Sequencer

This block drives the resets of a clock tree built in three tiers: a reference source, a PLL whose oscillator sits on its own supply rail, and a set of derived output branches fed by the PLL. Each tier comes out of reset only after everything above it is good, so release always runs in the same order: source first, then the PLL, then the branches once the PLL reports lock. Each tier also has a minimum-hold qualifier. The gating condition must stay true for a set number of cycles before the tier is released. A short wobble restarts the count and never opens a reset.

The branches are released one after another with a fixed cycle spacing, which spreads out the current surge at start-up. Loss of any upstream condition pulls every lower reset back within one cycle, with no stagger. If the PLL supply dips while the reference stays good, the block enters a degraded mode. The reference reset stays released, the PLL and branches are held, and a one-cycle event strobe marks both entry and exit. The length of the outage is kept on a saturating output. The normal qualified release sequence then resumes.

All reset outputs are active low: 0 means the tier is held in reset and 1 means it is released.

Top module: `clktree_rst_seq`

## Requirements
- R1: `src_rst_n_o` goes to 1 after `src_pg_i` has been sampled high on HOLD_REF consecutive rising edges, and returns to 0 on the first edge at which `src_pg_i` is sampled low.
- R2: `pll_rst_n_o` goes to 1 only after the condition (`src_rst_n_o` high, `src_pg_i` high and `vco_pg_i` high) has been sampled true on HOLD_PLL consecutive edges. `pll_rst_n_o` is never 1 while `src_rst_n_o` is 0.
- R3: Branch release needs `pll_rst_n_o`, `src_pg_i`, `vco_pg_i` and `pll_lock_i` all true for HOLD_LOCK consecutive edges. No branch is released while `pll_lock_i` stays low.
- R4: Bit i of `br_rst_n_o` rises exactly i*STAG cycles after bit 0. A higher-numbered bit is never 1 while a lower-numbered bit is 0.
- R5: A low sample of `src_pg_i`, `vco_pg_i` or `pll_lock_i` forces every reset below that input to 0 on that same edge. All branches fall together.
- R6: A qualifying condition that drops for even one cycle before its hold count completes restarts the count from zero.
- R7: When `src_rst_n_o` is 1, `src_pg_i` is high and `vco_pg_i` is sampled low, `degraded_o` becomes 1 on that edge. While `degraded_o` is 1, `src_rst_n_o` stays 1 and all `br_rst_n_o` bits are 0.
- R8: `degraded_o` stays 1 until `vco_pg_i` and `pll_lock_i` are sampled high together. It also clears if the reference is lost.
- R9: `event_o` is 1 for exactly the cycles in which `degraded_o` differs from its value in the previous cycle.
- R10: When `degraded_o` clears, `outage_len_o` takes the number of cycles `degraded_o` was 1, saturating at 2^DUR_W-1. It holds that value until the next exit from degraded mode.
- R11: While reset is applied and just after it is released, all reset outputs, `degraded_o`, `event_o` and `outage_len_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pg_i | input | 1 | Reference source rail good |
| vco_pg_i | input | 1 | PLL/oscillator rail good |
| pll_lock_i | input | 1 | PLL lock indication |
| src_rst_n_o | output | 1 | Reference reset, 1 = released |
| pll_rst_n_o | output | 1 | PLL reset, 1 = released |
| br_rst_n_o | output | NBR | Derived branch resets, 1 = released |
| degraded_o | output | 1 | Degraded mode active |
| event_o | output | 1 | One-cycle strobe on degraded entry and exit |
| outage_len_o | output | DUR_W | Cycles spent in the last degraded episode |

## Verification
The bench builds the block with three branches, hold counts of 4, 5 and 6, a stagger of 3 and a 4-bit outage field. With these values a full start-up, including every branch offset, fits in about twenty cycles. A dip longer than fifteen cycles reaches the outage saturation limit, while a three-cycle dip checks the exact count. Small holds also let single-cycle wobbles, lock drops and reference loss land in every phase of the sequence within a short run.

// File: rtl/clktree_seq_pkg.sv
package clktree_seq_pkg;

  // Next value of a counter that stops at lim.
  function automatic int unsigned sat_next(int unsigned v, int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // Cycle offset after the first branch at which branch idx opens.
  function automatic int unsigned stag_offset(int unsigned idx, int unsigned step);
    return idx * step;
  endfunction

  // Counter width able to hold the value lim.
  function automatic int unsigned cnt_width(int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  typedef struct packed {
    logic src_ok;
    logic vco_ok;
    logic lock_ok;
  } rail_state_t;

endpackage

// File: rtl/hold_qual.sv
module hold_qual
  import clktree_seq_pkg::*;
#(
  parameter int unsigned HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  output logic ok_o
);
  localparam int unsigned CW = cnt_width(HOLD);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!cond_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= CW'(sat_next(32'(cnt_q), HOLD));
    end
  end

  assign ok_o = (32'(cnt_q) == HOLD);

endmodule

// File: rtl/stagger_fan.sv
module stagger_fan
  import clktree_seq_pkg::*;
#(
  parameter int unsigned NBR  = 4,
  parameter int unsigned STAG = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go_i,
  output logic [NBR-1:0] rel_o
);
  localparam int unsigned SPAN = stag_offset(NBR - 1, STAG);
  localparam int unsigned SW   = cnt_width(SPAN);

  logic [SW-1:0] el_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      el_q <= '0;
    end else if (!go_i) begin
      el_q <= '0;
    end else begin
      el_q <= SW'(sat_next(32'(el_q), SPAN));
    end
  end

  for (genvar i = 0; i < NBR; i++) begin : g_br
    assign rel_o[i] = go_i && (32'(el_q) >= stag_offset(32'(i), STAG));
  end

endmodule

// File: rtl/degrade_mon.sv
module degrade_mon #(
  parameter int unsigned DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_up_i,
  input  logic             src_pg_i,
  input  logic             vco_pg_i,
  input  logic             lock_i,
  output logic             deg_o,
  output logic             evt_o,
  output logic [DUR_W-1:0] len_o
);
  logic             deg_q, evt_q;
  logic [DUR_W-1:0] dur_q, len_q;
  logic             deg_n;
  logic             enter_w, leave_w;

  always_comb begin
    if (!(src_up_i && src_pg_i)) begin
      deg_n = 1'b0;
    end else if (deg_q) begin
      deg_n = !(vco_pg_i && lock_i);
    end else begin
      deg_n = !vco_pg_i;
    end
  end

  assign enter_w = deg_n && !deg_q;
  assign leave_w = deg_q && !deg_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deg_q <= 1'b0;
      evt_q <= 1'b0;
      dur_q <= '0;
      len_q <= '0;
    end else begin
      deg_q <= deg_n;
      evt_q <= enter_w || leave_w;
      if (enter_w) begin
        dur_q <= DUR_W'(1);
      end else if (deg_q && (dur_q != '1)) begin
        dur_q <= dur_q + DUR_W'(1);
      end
      if (leave_w) begin
        len_q <= dur_q;
      end
    end
  end

  assign deg_o = deg_q;
  assign evt_o = evt_q;
  assign len_o = len_q;

endmodule

// File: rtl/clktree_rst_seq.sv
module clktree_rst_seq
  import clktree_seq_pkg::*;
#(
  parameter int unsigned NBR       = 4,
  parameter int unsigned HOLD_REF  = 16,
  parameter int unsigned HOLD_PLL  = 16,
  parameter int unsigned HOLD_LOCK = 32,
  parameter int unsigned STAG      = 64,
  parameter int unsigned DUR_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_pg_i,
  input  logic             vco_pg_i,
  input  logic             pll_lock_i,
  output logic             src_rst_n_o,
  output logic             pll_rst_n_o,
  output logic [NBR-1:0]   br_rst_n_o,
  output logic             degraded_o,
  output logic             event_o,
  output logic [DUR_W-1:0] outage_len_o
);
  rail_state_t rails;
  logic        src_up, pll_up, tree_go;
  logic        pll_cond, go_cond;

  assign rails.src_ok  = src_pg_i;
  assign rails.vco_ok  = vco_pg_i;
  assign rails.lock_ok = pll_lock_i;

  // Each tier is gated by every rail above it plus the registered tier above.
  assign pll_cond = src_up && rails.src_ok && rails.vco_ok;
  assign go_cond  = pll_up && rails.src_ok && rails.vco_ok && rails.lock_ok;

  hold_qual #(.HOLD(HOLD_REF)) u_src_q (
    .clk(clk), .rst_n(rst_n), .cond_i(rails.src_ok), .ok_o(src_up)
  );

  hold_qual #(.HOLD(HOLD_PLL)) u_pll_q (
    .clk(clk), .rst_n(rst_n), .cond_i(pll_cond), .ok_o(pll_up)
  );

  hold_qual #(.HOLD(HOLD_LOCK)) u_lock_q (
    .clk(clk), .rst_n(rst_n), .cond_i(go_cond), .ok_o(tree_go)
  );

  stagger_fan #(.NBR(NBR), .STAG(STAG)) u_fan (
    .clk(clk), .rst_n(rst_n), .go_i(tree_go), .rel_o(br_rst_n_o)
  );

  degrade_mon #(.DUR_W(DUR_W)) u_deg (
    .clk(clk), .rst_n(rst_n),
    .src_up_i(src_up), .src_pg_i(rails.src_ok),
    .vco_pg_i(rails.vco_ok), .lock_i(rails.lock_ok),
    .deg_o(degraded_o), .evt_o(event_o), .len_o(outage_len_o)
  );

  assign src_rst_n_o = src_up;
  assign pll_rst_n_o = pll_up;

endmodule

// File: rtl/clktree_rst_seq_chk.sv
module clktree_rst_seq_chk #(
  parameter int unsigned NBR   = 4,
  parameter int unsigned DUR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             src_pg_i,
  input logic             vco_pg_i,
  input logic             pll_lock_i,
  input logic             src_rst_n_o,
  input logic             pll_rst_n_o,
  input logic [NBR-1:0]   br_rst_n_o,
  input logic             degraded_o,
  input logic             event_o,
  input logic [DUR_W-1:0] outage_len_o
);
  a_r2_pll_under_src: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst_n_o |-> src_rst_n_o);

  a_r3_br_under_pll: assert property (@(posedge clk) disable iff (!rst_n)
    (br_rst_n_o != '0) |-> (pll_rst_n_o && src_rst_n_o));

  for (genvar i = 1; i < NBR; i++) begin : g_ord
    a_r4_order: assert property (@(posedge clk) disable iff (!rst_n)
      br_rst_n_o[i] |-> br_rst_n_o[i-1]);
  end

  a_r5_src_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !src_pg_i |=> (!src_rst_n_o && !pll_rst_n_o && (br_rst_n_o == '0)));

  a_r5_vco_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !vco_pg_i |=> (!pll_rst_n_o && (br_rst_n_o == '0)));

  a_r5_lock_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_lock_i |=> (br_rst_n_o == '0));

  a_r7_src_kept: assert property (@(posedge clk) disable iff (!rst_n)
    degraded_o |-> (src_rst_n_o && (br_rst_n_o == '0)));

  a_r9_evt_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (degraded_o != $past(degraded_o)) |-> event_o);

  a_r9_evt_only_change: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> (degraded_o != $past(degraded_o)));

  a_r10_len_set: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(degraded_o) |-> (outage_len_o != '0));

endmodule

bind clktree_rst_seq clktree_rst_seq_chk #(.NBR(NBR), .DUR_W(DUR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_pg_i(src_pg_i), .vco_pg_i(vco_pg_i),
  .pll_lock_i(pll_lock_i), .src_rst_n_o(src_rst_n_o), .pll_rst_n_o(pll_rst_n_o),
  .br_rst_n_o(br_rst_n_o), .degraded_o(degraded_o), .event_o(event_o),
  .outage_len_o(outage_len_o)
);

// File: tb/tb_clktree_rst_seq.sv
`timescale 1ns/1ps
module tb_clktree_rst_seq;
  localparam int NBR = 3, HREF = 4, HPLL = 5, HLOCK = 6, STAG = 3, DUR_W = 4;
  localparam int LMAX = (1 << DUR_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic src_pg = 1'b0, vco_pg = 1'b0, lock = 1'b0;
  logic src_rst_n, pll_rst_n, deg, evt;
  logic [NBR-1:0] br_rst_n;
  logic [DUR_W-1:0] olen;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clktree_rst_seq #(.NBR(NBR), .HOLD_REF(HREF), .HOLD_PLL(HPLL), .HOLD_LOCK(HLOCK),
                    .STAG(STAG), .DUR_W(DUR_W)) dut (
    .clk(clk), .rst_n(rst_n), .src_pg_i(src_pg), .vco_pg_i(vco_pg),
    .pll_lock_i(lock), .src_rst_n_o(src_rst_n), .pll_rst_n_o(pll_rst_n),
    .br_rst_n_o(br_rst_n), .degraded_o(deg), .event_o(evt), .outage_len_o(olen)
  );

  // Behavioural model: run lengths of each qualifying condition.
  int  run_src, run_pll, run_go, run_st, dur, m_len;
  bit  m_src, m_pll, m_go, m_deg, m_evt;
  logic [NBR-1:0] m_br;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_src = 0; run_pll = 0; run_go = 0; run_st = 0; dur = 0; m_len = 0;
      m_src = 0; m_pll = 0; m_go = 0; m_deg = 0; m_evt = 0; m_br = '0;
    end else begin
      bit c_pll, c_go, old_go, new_deg;
      c_pll  = m_src && src_pg && vco_pg;
      c_go   = m_pll && src_pg && vco_pg && lock;
      old_go = m_go;
      if (!(m_src && src_pg)) new_deg = 0;
      else if (m_deg) new_deg = !(vco_pg && lock);
      else new_deg = !vco_pg;
      run_src = src_pg ? run_src + 1 : 0;
      run_pll = c_pll ? run_pll + 1 : 0;
      run_go  = c_go ? run_go + 1 : 0;
      run_st  = old_go ? run_st + 1 : 0;
      m_src = (run_src >= HREF);
      m_pll = (run_pll >= HPLL);
      m_go  = (run_go >= HLOCK);
      if (!m_go) run_st = 0;
      for (int b = 0; b < NBR; b++) m_br[b] = m_go && (run_st >= b * STAG);
      m_evt = (new_deg != m_deg);
      if (m_deg && !new_deg) m_len = (dur > LMAX) ? LMAX : dur;
      if (new_deg) dur = m_deg ? dur + 1 : 1;
      m_deg = new_deg;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1", "src_rst_n model", int'(src_rst_n), int'(m_src));
      chk("R2", "pll_rst_n model", int'(pll_rst_n), int'(m_pll));
      chk("R4", "br_rst_n model", int'(br_rst_n), int'(m_br));
      chk("R7", "degraded model", int'(deg), int'(m_deg));
      chk("R9", "event model", int'(evt), int'(m_evt));
      chk("R10", "outage_len model", int'(olen), m_len);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    int first[NBR];
    step(3);
    rst_n = 1'b1;
    step(1);
    // R11: reset state
    chk("R11", "src_rst_n after reset", int'(src_rst_n), 0);
    chk("R11", "pll_rst_n after reset", int'(pll_rst_n), 0);
    chk("R11", "br_rst_n after reset", int'(br_rst_n), 0);
    chk("R11", "deg/evt/len after reset", int'({deg, evt, olen}), 0);

    // R6: wobble restarts the reference hold
    src_pg = 1'b1; step(2);
    src_pg = 1'b0; step(1);
    src_pg = 1'b1; step(HREF - 1);
    chk("R6", "src held after wobble", int'(src_rst_n), 0);
    step(1);
    chk("R1", "src released after hold", int'(src_rst_n), 1);

    // R2: PLL waits for its rail
    step(8);
    chk("R2", "pll held with vco low", int'(pll_rst_n), 0);
    vco_pg = 1'b1; step(HPLL);
    chk("R2", "pll released after hold", int'(pll_rst_n), 1);
    step(4);
    chk("R3", "branches held without lock", int'(br_rst_n), 0);

    // R3/R4: lock qualification and stagger
    lock = 1'b1;
    for (int b = 0; b < NBR; b++) first[b] = -1;
    for (int c = 1; c <= 30; c++) begin
      step(1);
      for (int b = 0; b < NBR; b++)
        if (br_rst_n[b] && first[b] < 0) first[b] = c;
    end
    chk("R3", "branch0 release delay", first[0], HLOCK);
    for (int b = 1; b < NBR; b++)
      chk("R4", "stagger between branches", first[b] - first[b-1], STAG);

    // R5: lock loss drops all branches at once, PLL stays up
    lock = 1'b0; step(1);
    chk("R5", "branches after lock loss", int'(br_rst_n), 0);
    chk("R5", "pll kept on lock loss", int'(pll_rst_n), 1);
    lock = 1'b1; step(HLOCK + (NBR - 1) * STAG + 1);
    chk("R3", "branches re-released", int'(br_rst_n), (1 << NBR) - 1);

    // R7/R8/R9/R10: long dip saturates outage length
    vco_pg = 1'b0; lock = 1'b0; step(1);
    chk("R7", "degraded entered", int'(deg), 1);
    chk("R9", "event on entry", int'(evt), 1);
    chk("R7", "src kept in degraded", int'(src_rst_n), 1);
    chk("R7", "pll/branches held", int'({pll_rst_n, br_rst_n}), 0);
    step(1);
    chk("R9", "event one cycle", int'(evt), 0);
    step(18);
    vco_pg = 1'b1; step(5);
    chk("R8", "degraded kept without lock", int'(deg), 1);
    lock = 1'b1; step(1);
    chk("R8", "degraded left on relock", int'(deg), 0);
    chk("R9", "event on exit", int'(evt), 1);
    chk("R10", "outage length saturated", int'(olen), LMAX);

    // R10: short dip exact length
    step(HLOCK + 10);
    vco_pg = 1'b0; step(3);
    chk("R7", "degraded during short dip", int'(deg), 1);
    vco_pg = 1'b1; step(1);
    chk("R10", "short outage length", int'(olen), 3);

    // R5: reference loss clears everything
    step(HPLL + HLOCK + 10);
    src_pg = 1'b0; step(1);
    chk("R5", "all resets on src loss", int'({src_rst_n, pll_rst_n, br_rst_n}), 0);
    chk("R8", "degraded clear on src loss", int'(deg), 0);
    step(3);
    finish_run();
  end

endmodule